// File: doc/BRIEF.md
# Saturating Digital Monitor Mixer

This block adds a scaled copy of the stereo capture stream to the stereo playback stream. Each capture sample is scaled down by one programmable attenuation, and the same setting applies to left and right. The scaled value is added to the matching playback sample, and the sum is clamped to the signed 16-bit range instead of wrapping. The mixed pair feeds the output attenuator further down the chain. The capture samples that go to the host are taken before this block, so they are not changed by it.

The attenuation has 64 steps of 1.5 dB, from 0 dB down to -94.5 dB. The two low bits of the setting select one of four fine coefficients, which cover 0, -1.5, -3 and -4.5 dB. The upper bits give a whole number of 6 dB steps, applied as an arithmetic right shift. A mute input removes the monitor contribution completely. All arithmetic uses 16-bit two's-complement linear PCM.

A one-cycle sample strobe loads the result into output registers. A valid flag goes high for the following cycle.

Top module: `mon_mix`

## Requirements
- R1: While reset is high and in the cycle after it, `mix_l`, `mix_r` and `mix_vld` are all zero.
- R2: The monitor term for a capture sample `c` and attenuation `a` (6 bits) is floor(c * K / 2^(15 + a/4)), where a/4 is integer division. K is selected by a mod 4: 0 gives 32768, 1 gives 27571, 2 gives 23198 and 3 gives 19519.
- R3: Left and right use the same attenuation value. Each channel's monitor term is formed only from its own capture sample.
- R4: When `mon_mute` is 1 in the strobe cycle, each mixed output equals its playback sample exactly, whatever the capture samples and attenuation are.
- R5: When the monitor path is not muted and playback plus monitor term lies within -32768..32767, the output equals that sum.
- R6: A sum above 32767 gives 7FFFh, and a sum below -32768 gives 8000h. The result never wraps.
- R7: Inputs present in a cycle where `smp_stb` is 1 set the outputs after that clock edge. `mix_vld` is 1 for exactly that following cycle and 0 in every other cycle.
- R8: In cycles without a strobe, the mixed outputs keep their last values, even when the data, attenuation and mute inputs change.
- R9: At attenuation 0 the monitor term equals the capture sample. At attenuation 63 a capture of -32768 gives a monitor term of -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe: the inputs hold a new sample pair |
| cap_l | input | 16 | Left capture sample, signed |
| cap_r | input | 16 | Right capture sample, signed |
| pb_l | input | 16 | Left playback sample, signed |
| pb_r | input | 16 | Right playback sample, signed |
| mon_atten | input | 6 | Monitor attenuation in 1.5 dB steps |
| mon_mute | input | 1 | 1 removes the monitor contribution |
| mix_l | output | 16 | Left mixed sample, signed |
| mix_r | output | 16 | Right mixed sample, signed |
| mix_vld | output | 1 | High for one cycle after a strobe |

## Verification
The bench builds the block with its default parameters: 16-bit samples and a 6-bit attenuation. With these values all four fine coefficients are reached, and so is every coarse shift from 0 to 15 places. Full-scale capture and playback values can drive the sum beyond either rail, so both clamps are exercised. Attenuation 63 applied to the most negative capture value reaches the floor-rounding corner, where the monitor term stays at -1.

// File: rtl/mon_mix_pkg.sv
package mon_mix_pkg;

  // Number of audio channels mixed in parallel
  localparam int NCH = 2;

  // Fraction bits of the fine-step coefficient (unity = 2**FRAC_W)
  localparam int FRAC_W = 15;

  // Fine-step coefficients for 0, -1.5, -3 and -4.5 dB, in unsigned Q1.FRAC_W
  function automatic logic [FRAC_W:0] fine_coef(input logic [1:0] idx);
    logic [FRAC_W:0] k;
    case (idx)
      2'd0:    k = 16'd32768;
      2'd1:    k = 16'd27571;
      2'd2:    k = 16'd23198;
      default: k = 16'd19519;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/mon_step_atten.sv
// Fine coefficient multiply followed by a coarse arithmetic shift
module mon_step_atten
  import mon_mix_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic signed [DW-1:0] din,
  input  logic        [AW-1:0] atten,
  output logic signed [DW-1:0] dout
);

  localparam int PW  = DW + FRAC_W + 1;
  localparam int CSW = AW - 2;

  logic        [FRAC_W:0] coef;
  logic        [CSW-1:0]  coarse;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   scaled;

  always_comb begin
    coef   = fine_coef(atten[1:0]);
    coarse = atten[AW-1:2];
    prod   = PW'(din) * $signed({1'b0, coef});
    scaled = prod >>> (FRAC_W + int'(coarse));
    dout   = DW'(scaled);
  end

endmodule

// File: rtl/mon_sat_add.sv
// Signed add with clamp to the representable range
module mon_sat_add #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] y
);

  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0] sum;

  always_comb begin
    sum = {a[DW-1], a} + {b[DW-1], b};
    if (sum[DW] != sum[DW-1])
      y = sum[DW] ? MINV : MAXV;
    else
      y = sum[DW-1:0];
  end

endmodule

// File: rtl/mon_mix.sv
module mon_mix
  import mon_mix_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] cap_l,
  input  logic signed [DW-1:0] cap_r,
  input  logic signed [DW-1:0] pb_l,
  input  logic signed [DW-1:0] pb_r,
  input  logic        [AW-1:0] mon_atten,
  input  logic                 mon_mute,
  output logic signed [DW-1:0] mix_l,
  output logic signed [DW-1:0] mix_r,
  output logic                 mix_vld
);

  logic signed [DW-1:0] cap_a [NCH];
  logic signed [DW-1:0] pb_a  [NCH];
  logic signed [DW-1:0] att_w [NCH];
  logic signed [DW-1:0] sum_w [NCH];
  logic signed [DW-1:0] mix_q [NCH];

  assign cap_a[0] = cap_l;
  assign cap_a[1] = cap_r;
  assign pb_a[0]  = pb_l;
  assign pb_a[1]  = pb_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    mon_step_atten #(.DW(DW), .AW(AW)) u_att (
      .din   (cap_a[ch]),
      .atten (mon_atten),
      .dout  (att_w[ch])
    );

    mon_sat_add #(.DW(DW)) u_add (
      .a (pb_a[ch]),
      .b (att_w[ch]),
      .y (sum_w[ch])
    );

    always_ff @(posedge clk) begin
      if (rst)
        mix_q[ch] <= '0;
      else if (smp_stb)
        mix_q[ch] <= mon_mute ? pb_a[ch] : sum_w[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mix_vld <= 1'b0;
    else     mix_vld <= smp_stb;
  end

  assign mix_l = mix_q[0];
  assign mix_r = mix_q[1];

  // R2
  att_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_l[DW-1] |-> (!att_w[0][DW-1] && att_w[0] <= cap_l));

  // R4
  mute_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && mon_mute) |=> (mix_l == $past(pb_l) && mix_r == $past(pb_r)));

  // R6
  no_wrap_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !mon_mute && !pb_l[DW-1] && !att_w[0][DW-1]) |=> !mix_l[DW-1]);

  // R6
  no_wrap_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !mon_mute && pb_r[DW-1] && att_w[1][DW-1]) |=> mix_r[DW-1]);

  // R7
  vld_src_chk: assert property (@(posedge clk) disable iff (rst)
    mix_vld |-> $past(smp_stb));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(mix_l) && $stable(mix_r)));

endmodule

// File: tb/mon_mix_tb.sv
module mon_mix_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst;
  logic smp_stb;
  logic signed [DW-1:0] cap_l, cap_r, pb_l, pb_r;
  logic [AW-1:0] mon_atten;
  logic mon_mute;
  logic signed [DW-1:0] mix_l, mix_r;
  logic mix_vld;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_mix #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb),
    .cap_l(cap_l), .cap_r(cap_r), .pb_l(pb_l), .pb_r(pb_r),
    .mon_atten(mon_atten), .mon_mute(mon_mute),
    .mix_l(mix_l), .mix_r(mix_r), .mix_vld(mix_vld)
  );

  function automatic longint coef_of(int a);
    case (a % 4)
      0: return 32768;
      1: return 27571;
      2: return 23198;
      default: return 19519;
    endcase
  endfunction

  function automatic int exp_att(int c, int a);
    longint p;
    p = longint'(c) * coef_of(a);
    return int'(p >>> (15 + a / 4));
  endfunction

  function automatic int exp_mix(int p, int c, int a, bit m);
    int s;
    if (m) return p;
    s = p + exp_att(c, a);
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply one strobed sample, then check outputs and the hold behaviour
  task automatic sample(string req, int cl, int cr, int pl, int pr, int a, bit m);
    int el, er;
    el = exp_mix(pl, cl, a, m);
    er = exp_mix(pr, cr, a, m);
    @(negedge clk);
    cap_l = DW'(cl); cap_r = DW'(cr); pb_l = DW'(pl); pb_r = DW'(pr);
    mon_atten = AW'(a); mon_mute = m; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    chk({req, " R7 vld"}, int'(mix_vld), 1);
    chk({req, " left"}, int'(mix_l), el);
    chk({req, " right"}, int'(mix_r), er);
    // R8: change every input without a strobe, outputs must hold
    cap_l = DW'($urandom); cap_r = DW'($urandom);
    pb_l = DW'($urandom); pb_r = DW'($urandom);
    mon_atten = AW'($urandom); mon_mute = ~m;
    @(negedge clk);
    chk("R7 vld low", int'(mix_vld), 0);
    chk("R8 hold left", int'(mix_l), el);
    chk("R8 hold right", int'(mix_r), er);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; smp_stb = 1'b0; mon_mute = 1'b0; mon_atten = '0;
    cap_l = '0; cap_r = '0; pb_l = '0; pb_r = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset vld", int'(mix_vld), 0);
    chk("R1 reset left", int'(mix_l), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset right", int'(mix_r), 0);
    chk("R1 after reset vld", int'(mix_vld), 0);

    // R9 / R5: unity gain
    sample("R9 unity", 1000, -2000, 300, 400, 0, 1'b0);
    // R6 positive and negative clamps
    sample("R6 clamp", 32767, -32768, 32767, -32768, 0, 1'b0);
    sample("R6 clamp half", 20000, -20000, 20000, -20000, 2, 1'b0);
    // R9 deepest attenuation floor corner
    sample("R9 max atten", -32768, 32767, 5, -5, 63, 1'b0);
    // R4 mute with full-scale capture
    sample("R4 mute", 32767, -32768, -1234, 32767, 0, 1'b1);
    // R3 shared attenuation, distinct channels
    sample("R3 shared", 12345, -321, 0, 0, 5, 1'b0);
    // R2 each fine step with several coarse shifts
    for (int a = 0; a < 64; a += 7)
      sample("R2 step", -30000, 29999, 10, -10, a, 1'b0);

    // Random mixture
    for (int i = 0; i < 300; i++) begin
      int cl, cr, pl, pr, a;
      bit m;
      cl = int'($signed(16'($urandom)));
      cr = int'($signed(16'($urandom)));
      pl = int'($signed(16'($urandom)));
      pr = int'($signed(16'($urandom)));
      a  = int'($urandom % 64);
      m  = ($urandom % 8) == 0;
      sample("R5 random", cl, cr, pl, pr, a, m);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule